// File: doc/BRIEF.md
# Parallel Spreading-Code Phase Acquisition

This block finds the phase of a repeating spreading code carried by an unmodulated pilot. Complex baseband samples arrive at two per chip together with a local replica of the code that starts at epoch zero. A symbol of L chips holds 2L candidate phases spaced half a chip apart. Every one of these hypotheses is tested at the same time by its own pair of I and Q correlators. Each correlator sees the replica delayed by a different number of half-chip samples.

After M symbols of coherent correlation, the I and Q results of each hypothesis are squared and added. This gives an energy that does not depend on carrier phase. Each hypothesis keeps a sum of W such energies. At the end of that window the block picks the hypothesis with the largest sum. The noise-plus-interference level is taken as the mean of the remaining hypotheses. The block reports the winning index and whether the peak clears a scaled version of that level. A start input restarts the whole search, and each decision is marked by a one-cycle pulse.

Top module: `pn_phase_search`

## Requirements
- R1: There are 2L hypotheses. Hypothesis k correlates each valid sample with the replica chip delayed by k valid samples, taken as zero before the first sample after start or reset. A replica bit of 0 means +1 and a bit of 1 means -1. For a clean pilot delayed by d samples, index d wins.
- R2: The energy of a hypothesis is I² + Q² of its correlator sums over 2L·M valid samples. A pilot placed only on I, or only on Q, gives the same winning index.
- R3: A window is W coherent periods, which is 2L·M·W valid samples. Cycles with s_valid low change nothing.
- R4: No correlator, energy or window sum overflows when every sample is at signed full scale.
- R5: phase is the index of the largest window sum. When two or more sums are equal, the lowest index wins, so all-equal or all-zero sums give index 0.
- R6: present is 1 only if max·(2L−1)·2^LF > lam·(sum−max). Here sum is the total of all window sums, and lam is unsigned with LF fraction bits. A peak exactly equal to the threshold gives 0.
- R7: done is a one-cycle pulse. It rises at the first clock edge after the edge that takes the last sample of a window. phase and present change only with done and hold at all other times.
- R8: start clears the correlators, window sums, counters, replica history and any pending decision. It sets phase and present to 0, and a sample offered in the same cycle is dropped.
- R9: After reset, done, phase and present are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Restart the search |
| s_valid | input | 1 | A sample is offered this cycle |
| s_i | input | SW | In-phase sample, signed |
| s_q | input | SW | Quadrature sample, signed |
| code_chip | input | 1 | Local replica chip for this sample (0 = +1, 1 = −1) |
| lam | input | LW | Threshold scale, LF fraction bits |
| done | output | 1 | Decision pulse |
| phase | output | $clog2(2L) | Winning half-chip index |
| present | output | 1 | Pilot detected |

## Verification
The bench drives pilots at several delays, with the carrier on I only, on Q only and rotated, and with gaps in s_valid. A design that shifted the replica in idle cycles, or counted idle cycles toward the window, would land on the wrong index. A constant input with an all-zero replica makes every sum equal. This exposes a wrong tie rule, and lam is stepped across the exact threshold to catch a comparison that is not strict. Full-scale samples test accumulator widths: an overflow would wrap the peak and move the index. A restart in the middle of a window must push the next pulse out by a whole window and clear the held result.

// File: rtl/pps_pkg.sv
package pps_pkg;
   // signed correlator width holding ns samples of sw bits plus negation headroom
   function automatic int corr_w(input int sw, input int ns);
      return sw + $clog2(ns) + 1;
   endfunction
   // window sum width for w energies of ew bits
   function automatic int win_w(input int ew, input int w);
      return ew + $clog2(w) + 1;
   endfunction
endpackage

// File: rtl/pps_timing.sv
module pps_timing #(
   parameter int NS = 64,
   parameter int W  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic s_valid,
   output logic dump,
   output logic fresh,
   output logic wlast
);
   localparam int SCW = $clog2(NS + 1);
   localparam int WCW = $clog2(W + 1);

   logic [SCW-1:0] samp;
   logic [WCW-1:0] coh;

   assign dump  = s_valid && !clr && (samp == SCW'(NS - 1));
   assign fresh = (coh == '0);
   assign wlast = dump && (coh == WCW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp <= '0;
         coh  <= '0;
      end else if (clr) begin
         samp <= '0;
         coh  <= '0;
      end else if (s_valid) begin
         if (dump) begin
            samp <= '0;
            coh  <= wlast ? '0 : coh + 1'b1;
         end else begin
            samp <= samp + 1'b1;
         end
      end
   end

   // R3: counters never leave their coherent and window ranges
   a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      (samp < SCW'(NS)) && (coh < WCW'(W)));
endmodule

// File: rtl/pps_bin.sv
module pps_bin #(
   parameter int SW  = 8,
   parameter int CW  = 16,
   parameter int SMW = 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 s_valid,
   input  logic                 chip,
   input  logic signed [SW-1:0] s_i,
   input  logic signed [SW-1:0] s_q,
   input  logic                 dump,
   input  logic                 fresh,
   output logic [SMW-1:0]       sm
);
   localparam int EW = 2 * CW;

   logic signed [CW-1:0] acc_i, acc_q;
   logic signed [CW-1:0] xi, xq, ni, nq;
   logic signed [EW-1:0] wi, wq, sq_i, sq_q;
   logic [EW-1:0]        energy;

   always_comb begin
      xi     = CW'(s_i);
      xq     = CW'(s_q);
      ni     = acc_i + (chip ? -xi : xi);
      nq     = acc_q + (chip ? -xq : xq);
      wi     = EW'(ni);
      wq     = EW'(nq);
      sq_i   = wi * wi;
      sq_q   = wq * wq;
      energy = sq_i + sq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_i <= '0;
         acc_q <= '0;
         sm    <= '0;
      end else if (clr) begin
         acc_i <= '0;
         acc_q <= '0;
         sm    <= '0;
      end else if (s_valid) begin
         if (dump) begin
            acc_i <= '0;
            acc_q <= '0;
            sm    <= fresh ? SMW'(energy) : sm + SMW'(energy);
         end else begin
            acc_i <= ni;
            acc_q <= nq;
         end
      end
   end

   // R4: inside a window the sum only grows, so it never wraps
   a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dump && !fresh) |=> (sm >= $past(sm)));
endmodule

// File: rtl/pps_decide.sv
module pps_decide #(
   parameter int NB   = 64,
   parameter int SMW  = 36,
   parameter int SUMW = 43,
   parameter int LW   = 8,
   parameter int LF   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    eval,
   input  logic [NB*SMW-1:0]       sm_flat,
   input  logic [LW-1:0]           lam,
   output logic                    done,
   output logic [$clog2(NB)-1:0]   phase,
   output logic                    present
);
   localparam int PW   = $clog2(NB);
   localparam int CMPW = SUMW + LW + LF + 1;

   logic [SMW-1:0]  best, v;
   logic [SUMW-1:0] total;
   logic [PW-1:0]   idx;
   logic [CMPW-1:0] lhs, rhs;
   logic            hit;

   always_comb begin
      best  = sm_flat[SMW-1:0];
      idx   = '0;
      total = '0;
      for (int k = 0; k < NB; k++) begin
         v     = sm_flat[k*SMW +: SMW];
         total = total + SUMW'(v);
         if (v > best) begin
            best = v;
            idx  = PW'(k);
         end
      end
      lhs = (CMPW'(best) * CMPW'(NB - 1)) << LF;
      rhs = CMPW'(lam) * CMPW'(total - SUMW'(best));
      hit = lhs > rhs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         phase   <= '0;
         present <= 1'b0;
      end else if (clr) begin
         done    <= 1'b0;
         phase   <= '0;
         present <= 1'b0;
      end else begin
         done <= eval;
         if (eval) begin
            phase   <= idx;
            present <= hit;
         end
      end
   end

   // R7: decision is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: results hold between decisions
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval && !clr) |=> ($stable(phase) && $stable(present)));
   // R8: a restart leaves a cleared result behind
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!done && !present && phase == '0));
endmodule

// File: rtl/pn_phase_search.sv
module pn_phase_search #(
   parameter int L  = 32,
   parameter int M  = 4,
   parameter int W  = 8,
   parameter int SW = 8,
   parameter int LW = 8,
   parameter int LF = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       s_valid,
   input  logic signed [SW-1:0]       s_i,
   input  logic signed [SW-1:0]       s_q,
   input  logic                       code_chip,
   input  logic [LW-1:0]              lam,
   output logic                       done,
   output logic [$clog2(2*L)-1:0]     phase,
   output logic                       present
);
   import pps_pkg::*;

   localparam int NB   = 2 * L;
   localparam int NS   = NB * M;
   localparam int CW   = corr_w(SW, NS);
   localparam int EW   = 2 * CW;
   localparam int SMW  = win_w(EW, W);
   localparam int SUMW = SMW + $clog2(NB) + 1;

   if (L < 2)                 begin : g_bad_l  $error("L must be at least 2"); end
   if (M < 1 || W < 1)        begin : g_bad_mw $error("M and W must be positive"); end
   if (L * M * W > 512000)    begin : g_bad_lat $error("L*M*W exceeds acquisition-time budget"); end
   if (LF >= LW)              begin : g_bad_lf $error("LF must be below LW"); end

   logic              dump, fresh, wlast, eval;
   logic [NB-2:0]     cd;
   logic [NB-1:0]     taps;
   logic [NB*SMW-1:0] sm_flat;

   assign taps = {cd, code_chip};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd   <= '0;
         eval <= 1'b0;
      end else begin
         eval <= wlast;
         if (start)
            cd <= '0;
         else if (s_valid)
            cd <= {cd[NB-3:0], code_chip};
      end
   end

   pps_timing #(.NS(NS), .W(W)) u_timing (
      .clk(clk), .rst_n(rst_n), .clr(start), .s_valid(s_valid),
      .dump(dump), .fresh(fresh), .wlast(wlast));

   for (genvar k = 0; k < NB; k++) begin : g_bin
      pps_bin #(.SW(SW), .CW(CW), .SMW(SMW)) u_bin (
         .clk(clk), .rst_n(rst_n), .clr(start), .s_valid(s_valid),
         .chip(taps[k]), .s_i(s_i), .s_q(s_q), .dump(dump), .fresh(fresh),
         .sm(sm_flat[k*SMW +: SMW]));
   end

   pps_decide #(.NB(NB), .SMW(SMW), .SUMW(SUMW), .LW(LW), .LF(LF)) u_decide (
      .clk(clk), .rst_n(rst_n), .clr(start), .eval(eval), .sm_flat(sm_flat),
      .lam(lam), .done(done), .phase(phase), .present(present));

   // R7: a decision pulse only follows the close of a window
   a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(eval));
endmodule

// File: tb/test_pn_phase_search.sv
module test_pn_phase_search;
   localparam int CLK_PERIOD = 10;
   localparam int L  = 4;
   localparam int M  = 2;
   localparam int W  = 3;
   localparam int SW = 6;
   localparam int LW = 8;
   localparam int LF = 4;
   localparam int NB = 2 * L;
   localparam int NS = NB * M;
   localparam int PW = $clog2(NB);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, s_valid = 1'b0, code_chip = 1'b0;
   logic signed [SW-1:0] s_i = '0, s_q = '0;
   logic [LW-1:0] lam = 8'd32;
   logic done, present;
   logic [PW-1:0] phase;

   always #(CLK_PERIOD/2) clk = ~clk;

   pn_phase_search #(.L(L), .M(M), .W(W), .SW(SW), .LW(LW), .LF(LF)) i_pn_phase_search (
      .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
      .code_chip(code_chip), .lam(lam), .done(done), .phase(phase), .present(present));

   int total = 0, bad = 0;
   string cur_req = "R9";

   // behavioural reference
   longint m_ai[NB], m_aq[NB], m_sm[NB];
   bit     m_hist[NB];
   int     m_samp, m_coh;
   bit     m_pend, e_done, e_pres;
   int     e_phase;
   int     n_idx;

   function automatic void model_clear();
      for (int k = 0; k < NB; k++) begin
         m_ai[k] = 0; m_aq[k] = 0; m_sm[k] = 0; m_hist[k] = 0;
      end
      m_samp = 0; m_coh = 0; m_pend = 0;
   endfunction

   task automatic model_step();
      longint best, sum, xi, xq;
      int idx;
      bit c;
      if (!rst_n) begin
         model_clear(); e_done = 0; e_phase = 0; e_pres = 0;
         return;
      end
      e_done = m_pend;
      if (m_pend) begin
         best = m_sm[0]; idx = 0; sum = 0;
         for (int k = 0; k < NB; k++) begin
            sum += m_sm[k];
            if (m_sm[k] > best) begin best = m_sm[k]; idx = k; end
         end
         e_phase = idx;
         e_pres  = (best * (NB - 1) * (1 << LF)) > (longint'(lam) * (sum - best));
      end
      m_pend = 0;
      if (start) begin
         model_clear(); e_done = 0; e_phase = 0; e_pres = 0;
         return;
      end
      if (s_valid) begin
         xi = s_i; xq = s_q;
         for (int k = 0; k < NB; k++) begin
            c = (k == 0) ? code_chip : m_hist[k];
            m_ai[k] += c ? -xi : xi;
            m_aq[k] += c ? -xq : xq;
         end
         m_samp++;
         if (m_samp == NS) begin
            for (int k = 0; k < NB; k++) begin
               longint e = m_ai[k] * m_ai[k] + m_aq[k] * m_aq[k];
               m_sm[k] = (m_coh == 0) ? e : m_sm[k] + e;
               m_ai[k] = 0; m_aq[k] = 0;
            end
            m_samp = 0;
            if (m_coh == W - 1) begin m_pend = 1; m_coh = 0; end
            else m_coh++;
         end
         for (int k = NB - 1; k >= 2; k--) m_hist[k] = m_hist[k-1];
         m_hist[1] = code_chip;
      end
   endtask

   task automatic compare();
      total++;
      if (done !== e_done || phase !== PW'(e_phase) || present !== e_pres) begin
         bad++;
         $display("FAIL %s: done/phase/present act=%0b/%0d/%0b exp=%0b/%0d/%0b",
                  cur_req, done, phase, present, e_done, e_phase, e_pres);
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   function automatic bit pn_bit(input int i);
      return bit'((4'b0100 >> (i % L)) & 1);
   endfunction

   function automatic logic signed [SW-1:0] sat(input int v);
      if (v > 31) return 6'sd31;
      if (v < -32) return -6'sd32;
      return SW'(v);
   endfunction

   // one cycle of pilot stimulus: delay d half-chips, amplitudes ai/aq
   task automatic send(input int d, input int ai, input int aq, input int noise,
                       input int pv, input bit flat);
      bit rc;
      s_valid = ($urandom_range(99) < pv);
      if (s_valid) begin
         code_chip = flat ? 1'b0 : pn_bit(n_idx / 2);
         rc = flat ? 1'b0 : pn_bit((n_idx + 1000 * NB - d) / 2);
         s_i = sat((rc ? -ai : ai) + (noise > 0 ? $urandom_range(2*noise) - noise : 0));
         s_q = sat((rc ? -aq : aq) + (noise > 0 ? $urandom_range(2*noise) - noise : 0));
         n_idx++;
      end
      tick();
   endtask

   task automatic restart();
      start = 1'b1; s_valid = 1'b1; s_i = 6'sd20; s_q = 6'sd20;
      tick();
      start = 1'b0; n_idx = 0;
   endtask

   task automatic run_windows(input int nwin, input int d, input int ai, input int aq,
                              input int noise, input int pv, input bit flat);
      int cnt = 0;
      while (cnt < nwin) begin
         send(d, ai, aq, noise, pv, flat);
         if (done) cnt++;
      end
      s_valid = 1'b0;
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      model_clear(); e_done = 0; e_phase = 0; e_pres = 0; n_idx = 0;
      @(negedge clk);
      repeat (3) tick();
      check(done == 0 && phase == 0 && present == 0, "R9", "reset outputs",
            {done, phase, present}, 0);
      rst_n = 1'b1;
      tick();

      cur_req = "R1/R5/R6";
      restart();
      run_windows(2, 5, 12, -9, 2, 100, 0);
      check(phase == 5, "R1", "pilot delay 5 index", phase, 5);
      check(present == 1, "R6", "strong pilot detected", present, 1);

      cur_req = "R3";
      restart();
      run_windows(2, 3, 12, 9, 2, 60, 0);
      check(phase == 3, "R3", "gapped input index", phase, 3);

      cur_req = "R2";
      restart();
      run_windows(2, 6, 0, 14, 1, 100, 0);
      check(phase == 6, "R2", "Q-only pilot index", phase, 6);
      restart();
      run_windows(2, 6, 14, 0, 1, 100, 0);
      check(phase == 6, "R2", "I-only pilot index", phase, 6);

      cur_req = "R4";
      restart();
      run_windows(2, 2, -32, -32, 0, 100, 0);
      check(phase == 2, "R4", "full-scale index", phase, 2);
      check(present == 1, "R4", "full-scale detected", present, 1);

      cur_req = "R8";
      restart();
      check(present == 0 && phase == 0, "R8", "start clears result",
            {phase, present}, 0);

      cur_req = "R5";
      run_windows(1, 0, 0, 0, 0, 100, 0);
      check(phase == 0 && present == 0, "R5", "all-zero sums", {phase, present}, 0);

      cur_req = "R5/R6";
      restart();
      run_windows(1, 0, 10, 5, 0, 100, 1);
      check(phase == 0, "R5", "equal sums pick lowest", phase, 0);
      check(present == 0, "R6", "equal sums lam=2.0", present, 0);
      lam = 8'd16;
      run_windows(1, 0, 10, 5, 0, 100, 1);
      check(present == 0, "R6", "peak equal to threshold", present, 0);
      lam = 8'd8;
      run_windows(1, 0, 10, 5, 0, 100, 1);
      check(present == 1, "R6", "lam=0.5 clears threshold", present, 1);
      lam = 8'd32;

      cur_req = "R7/R8";
      restart();
      repeat (20) send(1, 12, 3, 0, 100, 0);
      restart();
      cnt = 0;
      do begin
         send(1, 12, 3, 0, 100, 0);
         cnt++;
      end while (!done && cnt < 200);
      check(cnt == NB * M * W + 1, "R7", "cycles from restart to done", cnt,
            NB * M * W + 1);
      send(1, 12, 3, 0, 100, 0);
      check(done == 0, "R7", "done lasts one cycle", done, 0);
      repeat (5) send(1, 12, 3, 0, 100, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule